// File: doc/BRIEF.md
# Half-Duplex Converter Interface Controller

This controller sits on the host side of a time-division-duplex data converter in which one parallel bus is shared. The bus carries seven bits from the host to a transmit DAC, or five bits from a receive ADC back to the host. A two-bit mode request selects sending, receiving or idle. The controller drives the converter's two enable lines from that request. It holds all data traffic off until the converter's wake-up time has elapsed, and it decides when the host may drive the shared lines.

In transmit, samples arrive on a valid/ready stream and are registered onto the bus on the rising clock edge. The converter latches them on the following falling edge. In receive, the ADC code is captured on the falling edge, sign-extended to the host word width and delivered with a one-cycle valid flag. Leaving a mode always passes through one cycle of shutdown encoding, and the wake-up timer then runs again. The converter clock is the controller's own clock.

Top module: `tdd_conv_ctrl`

## Requirements
- R1: The enable lines follow the active direction. Transmit drives tx_en=1, rx_en=0. Receive drives rx_en=1, tx_en=0. Idle drives both low. The two lines are never high together.
- R2: After leaving shutdown, tx_ready, rx_valid and bus_oe stay low and bus_out stays 0 for exactly WAKE_CYC = ceil(2.4 us x CLK_KHZ kHz) cycles, counted from the edge that sets an enable line. The 2.4 us is that ceiling. With the default of 15000 kHz this is 36 cycles.
- R3: In active transmit, tx_ready is high every cycle and bus_oe is high. A sample accepted on a rising edge (tx_valid=1) appears on bus_out[6:0] right after that edge. bus_out is two's complement, so 0111111 is positive full scale and 1000000 is negative full scale.
- R4: In active receive, the code on bus_in[4:0] at a falling edge appears on rx_data after the next rising edge, sign-extended from bit 4, with rx_valid=1. For example, 01111 gives +15, 10000 gives -16 and 11111 gives -1.
- R5: bus_oe is low and bus_out is all zero whenever the controller is not in active transmit, including shutdown and receive.
- R6: A change of requested direction while waking or active drives both enable lines low for exactly one cycle, then sets the new enable and restarts the full wake-up wait.
- R7: In active transmit, a cycle with tx_valid=0 drives the zero code 0000000 onto the bus.
- R8: A mode_req value of 2'b11 is treated as idle, the same as 2'b00. 2'b01 requests transmit and 2'b10 requests receive.
- R9: During and right after reset, both enable lines, bus_oe, tx_ready and rx_valid are low and bus_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested mode: 01 transmit, 10 receive, 00/11 idle |
| tx_valid | input | 1 | Transmit sample valid |
| tx_data | input | 7 | Transmit sample, two's complement |
| tx_ready | output | 1 | Transmit sample accepted this cycle |
| rx_data | output | HOST_W | Sign-extended receive sample |
| rx_valid | output | 1 | One-cycle flag per receive sample |
| conv_tx_en | output | 1 | Converter transmit enable |
| conv_rx_en | output | 1 | Converter receive enable |
| bus_out | output | 7 | Host drive value for shared data lines |
| bus_oe | output | 1 | Host output enable for shared data lines |
| bus_in | input | 5 | Low five shared data lines as read by host |

## Verification
A corrupted wake counter shows up at the ports as tx_ready, bus_oe or rx_valid rising one or more cycles too early or too late after the enable line is set. The bench compares that against the cycle it computes itself. A wrong direction state appears within one cycle as an enable pattern that disagrees with the request, or as bus_oe high outside transmit. A missing pass through shutdown appears on the edge that follows the request change. A wrong capture edge or a wrong sign extension shows on the first receive sample, because every table code carries a distinct expected integer.

// File: rtl/tdd_ctl_pkg.sv
package tdd_ctl_pkg;
  localparam int DAC_W = 7;
  localparam int ADC_W = 5;

  typedef enum logic [1:0] {PH_OFF, PH_WAKE, PH_LIVE} phase_t;
  typedef enum logic {DIR_TX, DIR_RX} dir_t;

  // cycles covering 2.4 us, rounded up; clock given in kHz
  function automatic int unsigned wake_cycles(int unsigned clk_khz);
    return (clk_khz * 24 + 9999) / 10000;
  endfunction

  function automatic logic req_is_tx(logic [1:0] req);
    return req == 2'b01;
  endfunction

  function automatic logic req_is_rx(logic [1:0] req);
    return req == 2'b10;
  endfunction
endpackage

// File: rtl/tdd_wake_timer.sv
module tdd_wake_timer #(
  parameter int unsigned CYC = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  assert_load_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> cnt == LOAD);
endmodule

// File: rtl/tdd_mode_fsm.sv
module tdd_mode_fsm
  import tdd_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       wake_done,
  output phase_t     phase,
  output dir_t       dir,
  output logic       wake_start
);
  logic req_any, req_same;

  assign req_any    = req_is_tx(mode_req) || req_is_rx(mode_req);
  assign req_same   = (dir == DIR_TX) ? req_is_tx(mode_req) : req_is_rx(mode_req);
  assign wake_start = (phase == PH_OFF) && req_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      dir   <= DIR_TX;
    end else begin
      unique case (phase)
        PH_OFF: if (req_any) begin
          phase <= PH_WAKE;
          dir   <= req_is_tx(mode_req) ? DIR_TX : DIR_RX;
        end
        PH_WAKE: if (!req_same)     phase <= PH_OFF;
                 else if (wake_done) phase <= PH_LIVE;
        PH_LIVE: if (!req_same)     phase <= PH_OFF;
        default: phase <= PH_OFF;
      endcase
    end
  end

  // a direction flip always passes through the off phase
  assert_flip_via_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_OFF && $past(phase) != PH_OFF) |-> $stable(dir));
endmodule

// File: rtl/tdd_tx_drive.sv
module tdd_tx_drive
  import tdd_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live_tx,
  input  logic             tx_valid,
  input  logic [DAC_W-1:0] tx_data,
  output logic             tx_ready,
  output logic [DAC_W-1:0] bus_out,
  output logic             bus_oe
);
  logic [DAC_W-1:0] hold_q;

  assign tx_ready = live_tx;

  // registered on the rising edge, stable for the converter's falling-edge latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hold_q <= '0;
    else if (live_tx && tx_valid) hold_q <= tx_data;
    else                          hold_q <= '0;
  end

  assign bus_oe  = live_tx;
  assign bus_out = live_tx ? hold_q : '0;

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_tx && $past(live_tx) && !$past(tx_valid)) |-> bus_out == '0);
endmodule

// File: rtl/tdd_rx_capture.sv
module tdd_rx_capture
  import tdd_ctl_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_rx,
  input  logic [ADC_W-1:0]  bus_in,
  output logic [HOST_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int EXT = HOST_W - ADC_W;

  function automatic logic [HOST_W-1:0] widen(logic [ADC_W-1:0] c);
    return {{EXT{c[ADC_W-1]}}, c};
  endfunction

  logic [ADC_W-1:0] cap_q;

  // ADC output settles after the rising edge; take it on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= live_rx;
      if (live_rx) rx_data <= widen(cap_q);
    end
  end

  assert_valid_after_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(live_rx));
endmodule

// File: rtl/tdd_conv_ctrl.sv
module tdd_conv_ctrl
  import tdd_ctl_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 15000,
  parameter int          HOST_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_req,
  input  logic              tx_valid,
  input  logic [DAC_W-1:0]  tx_data,
  output logic              tx_ready,
  output logic [HOST_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              conv_tx_en,
  output logic              conv_rx_en,
  output logic [DAC_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [ADC_W-1:0]  bus_in
);
  localparam int unsigned WAKE_CYC = wake_cycles(CLK_KHZ);

  phase_t phase;
  dir_t   dir;
  logic   wake_start, wake_done;
  logic   live_tx, live_rx, waking;

  tdd_mode_fsm u_fsm (
    .clk, .rst_n, .mode_req, .wake_done,
    .phase, .dir, .wake_start
  );

  tdd_wake_timer #(.CYC(WAKE_CYC)) u_timer (
    .clk, .rst_n, .start(wake_start), .done(wake_done)
  );

  assign waking  = (phase == PH_WAKE);
  assign live_tx = (phase == PH_LIVE) && (dir == DIR_TX);
  assign live_rx = (phase == PH_LIVE) && (dir == DIR_RX);

  assign conv_tx_en = (phase != PH_OFF) && (dir == DIR_TX);
  assign conv_rx_en = (phase != PH_OFF) && (dir == DIR_RX);

  tdd_tx_drive u_tx (
    .clk, .rst_n, .live_tx, .tx_valid, .tx_data,
    .tx_ready, .bus_out, .bus_oe
  );

  tdd_rx_capture #(.HOST_W(HOST_W)) u_rx (
    .clk, .rst_n, .live_rx, .bus_in, .rx_data, .rx_valid
  );

  assert_enables_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_tx_en && conv_rx_en));
  assert_wake_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> (!tx_ready && !bus_oe));
  assert_oe_only_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (conv_tx_en && !conv_rx_en));
  assert_no_drive_shut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_tx_en == conv_rx_en) |-> (bus_out == '0 && !bus_oe));
  assert_no_direct_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rx_en |-> !$past(conv_tx_en));
  assert_no_direct_flip_rev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tx_en |-> !$past(conv_rx_en));
endmodule

// File: tb/sim_tdd_conv_ctrl.sv
module sim_tdd_conv_ctrl;
  localparam int PERIOD  = 10;
  localparam int CLK_KHZ = 15000;
  localparam int HOST_W  = 8;
  // 2.4 us at CLK_KHZ, rounded up: 12/5000 of a kHz count
  localparam int WAKE = (CLK_KHZ * 12 + 4999) / 5000;

  typedef struct packed { logic [4:0] code; int val; } rxvec_t;
  localparam rxvec_t RXTAB [6] = '{
    '{5'b01111, 15}, '{5'b10000, -16}, '{5'b00000, 0},
    '{5'b11111, -1}, '{5'b00001, 1},  '{5'b10101, -11}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_req = 2'b00;
  logic tx_valid = 0;
  logic [6:0] tx_data = '0;
  logic [4:0] bus_in = '0;
  logic tx_ready, rx_valid, conv_tx_en, conv_rx_en, bus_oe;
  logic [HOST_W-1:0] rx_data;
  logic [6:0] bus_out;
  int tests = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  tdd_conv_ctrl #(.CLK_KHZ(CLK_KHZ), .HOST_W(HOST_W)) u0 (
    .clk, .rst_n, .mode_req, .tx_valid, .tx_data, .tx_ready,
    .rx_data, .rx_valid, .conv_tx_en, .conv_rx_en, .bus_out, .bus_oe, .bus_in
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int ens();
    return {30'd0, conv_tx_en, conv_rx_en};
  endfunction

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD*2 + 1);
    chk(ens() == 0 && !bus_oe && !tx_ready && !rx_valid && bus_out == 0, "R9 in reset", ens(), 0);
    rst_n = 1;
    step();
    chk(ens() == 0 && !bus_oe && bus_out == 0, "R9 after reset", ens(), 0);

    mode_req = 2'b11;
    step(); step();
    chk(ens() == 0 && !tx_ready && !rx_valid, "R8 req 11 idle", ens(), 0);
    mode_req = 2'b00;
    step();

    // transmit wake-up, data offered but must be ignored
    mode_req = 2'b01; tx_valid = 1; tx_data = 7'h55;
    for (int i = 0; i < WAKE; i++) begin
      step();
      chk(ens() == 2, "R1 tx enables", ens(), 2);
      chk(!tx_ready && !bus_oe && bus_out == 0, "R2 tx wake quiet", bus_out, 0);
    end
    step();
    chk(tx_ready && bus_oe, "R2 tx live on time", tx_ready, 1);
    tx_data = 7'h3F;
    step();
    chk(bus_out == 7'h3F, "R3 +full scale", bus_out, 7'h3F);
    tx_data = 7'h40;
    step();
    chk(bus_out == 7'h40 && tx_ready, "R3 -full scale", bus_out, 7'h40);
    tx_valid = 0;
    step();
    chk(bus_out == 0 && bus_oe, "R7 no sample zero code", bus_out, 0);

    // direct switch to receive
    mode_req = 2'b10; bus_in = 5'b11111;
    step();
    chk(ens() == 0, "R6 one off cycle", ens(), 0);
    chk(!bus_oe && bus_out == 0, "R5 released in off", bus_out, 0);
    step();
    chk(ens() == 1, "R6 rx enable next", ens(), 1);
    for (int i = 1; i < WAKE; i++) begin
      step();
      chk(!rx_valid && ens() == 1, "R2 rx wake quiet", rx_valid, 0);
    end
    step();
    chk(!rx_valid && !bus_oe, "R5 rx bus released", bus_oe, 0);

    foreach (RXTAB[k]) begin
      bus_in = RXTAB[k].code;
      step();
      chk(rx_valid && $signed(rx_data) == RXTAB[k].val, "R4 rx code",
          $signed(rx_data), RXTAB[k].val);
      chk(!bus_oe && bus_out == 0, "R5 no drive in rx", bus_out, 0);
    end

    mode_req = 2'b00;
    step(); step();
    chk(ens() == 0 && !rx_valid && !bus_oe, "R1 idle enables", ens(), 0);

    // abort a wake-up midway: back to off on the next cycle
    mode_req = 2'b10;
    step(); step(); step();
    mode_req = 2'b00;
    step();
    chk(ens() == 0 && !rx_valid, "R6 abort wake", ens(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule